// File: doc/BRIEF.md
# External Interrupt Trigger Configurator

This block conditions a small group of external interrupt pins, four by default and at most six, and turns each one into a masked request line. Every pin is brought into the clock domain through a two-stage synchronizer. A programmable trigger mode then decides whether the line follows the pin level (active high or active low) or captures an edge (rising, falling or either). Captured edges are held in a per-line sticky flag until software acknowledges them.

Control sits in two 32-bit registers behind a plain write/read port. Register 0 serves lines 0 to 3 and register 1 serves lines 4 and 5. Within a register, line n uses field slot n mod 4 of each control group. The per-line outputs either feed a downstream interrupt aggregator or drive processor request inputs directly, and that choice is made outside this block. The block carries no data stream, so it has no valid/ready handshake. Its register port and its pins are plain level or strobe signals: a write takes effect at the clock edge where `wr_en` is high, and reads are combinational.

Top module: `eirq_trigger_cfg`

## Requirements
- R1: After reset, `irq_o` is all zero and each line is in level-low mode with its mask clear. With six lines and pins low, register 0 reads 0x000F0000 and register 1 reads 0x00030000.
- R2: Each register uses this layout, with one bit per field slot: bits [3:0] acknowledge, [7:4] mask, [11:8] polarity, [15:12] any-edge, [19:16] level-select, [23:20] read-only synchronized pin status. A write replaces every writable field. Acknowledge bits and bits [31:24] always read 0.
- R3: Lines 0 to 3 are controlled by register 0 (address 0) and lines 4 and 5 by register 1 (address 1), in slot line mod 4. The slots of lines at or above the configured count read 0 and ignore writes.
- R4: With level-select=1, a line outputs mask AND (synchronized pin == polarity) with no latching. The output reflects a pin change two clock edges after the change.
- R5: With level-select=0, any-edge=0 and polarity=1, a rising pin edge sets the flag. The output rises on the third clock edge after the pin change and stays high after the pin falls.
- R6: With all three mode bits 0, a falling pin edge sets the flag, and a rising edge does not.
- R7: With level-select=0 and any-edge=1, either pin edge sets the flag.
- R8: A clear mask bit forces that line's output to 0 without discarding a held flag. Setting the mask again shows the flag.
- R9: Writing 1 to a line's acknowledge bit clears its flag at that write edge. Writing 0 leaves the flag unchanged.
- R10: When an edge is detected in the same cycle as an acknowledge write for that line, the flag stays set.
- R11: The status bits [23:20] show each synchronized pin level, two clock edges after the pin changes.
- R12: Level-select takes precedence over any-edge. With both set, the line behaves as a level line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_LINES | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select for writes (0 or 1) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Register select for reads |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | NUM_LINES | Masked interrupt request per line |

## Verification
A corrupted sticky flag shows up on `irq_o` of a masked edge-mode line in the cycle after the faulty update, and it stays visible until the next acknowledge. A synchronizer or previous-value stage that is off by one shifts the edge-mode output away from the third clock edge, or the level-mode output and status bits away from the second edge, so latency is sampled at exact cycles. A wrong field decode is caught two ways: by full-register readback after a write, and by driving a pin on a line that lives in the second register while checking its neighbours.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int REG_W     = 32;
  localparam int SLOTS     = 4;
  localparam int MAX_LINES = 6;
  localparam int CLR_LSB   = 0;
  localparam int MASK_LSB  = 4;
  localparam int POL_LSB   = 8;
  localparam int ANY_LSB   = 12;
  localparam int LVL_LSB   = 16;
  localparam int RAW_LSB   = 20;

  typedef struct packed {
    logic lvl;
    logic pol;
    logic any;
  } trig_cfg_t;

  typedef enum logic [1:0] {
    TRIG_LEVEL,
    TRIG_RISE,
    TRIG_FALL,
    TRIG_BOTH
  } trig_kind_t;

  function automatic trig_kind_t trig_decode(trig_cfg_t c);
    if (c.lvl)      return TRIG_LEVEL;
    else if (c.any) return TRIG_BOTH;
    else if (c.pol) return TRIG_RISE;
    else            return TRIG_FALL;
  endfunction
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], d};
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/eirq_line.sv
module eirq_line
  import eirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_s,
  input  logic      pin_prev,
  input  trig_cfg_t cfg,
  input  logic      mask,
  input  logic      clr,
  output logic      irq
);
  trig_kind_t kind;
  logic       rise, fall, evt, flag_q;

  assign kind = trig_decode(cfg);
  assign rise = pin_s & ~pin_prev;
  assign fall = ~pin_s & pin_prev;

  always_comb begin
    unique case (kind)
      TRIG_RISE: evt = rise;
      TRIG_FALL: evt = fall;
      TRIG_BOTH: evt = rise | fall;
      default:   evt = 1'b0;
    endcase
  end

  // an edge beats a same-cycle acknowledge
  always_ff @(posedge clk) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (evt) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign irq = mask & ((kind == TRIG_LEVEL) ? (pin_s == cfg.pol) : flag_q);

  // R10
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && clr) |=> flag_q);
  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr && !evt) |=> !flag_q);
  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          wr_addr,
  input  logic [REG_W-1:0]              wr_data,
  input  logic                          rd_addr,
  input  logic [NUM_LINES-1:0]          raw,
  output trig_cfg_t [NUM_LINES-1:0]     cfg,
  output logic [NUM_LINES-1:0]          mask,
  output logic [NUM_LINES-1:0]          clr,
  output logic [REG_W-1:0]              rd_data
);
  logic unused_wr;
  assign unused_wr = ^wr_data;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam int LREG = g / SLOTS;
    localparam int FLD  = g % SLOTS;
    logic sel;
    assign sel = wr_en && (wr_addr == 1'(LREG));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask[g] <= 1'b0;
        cfg[g]  <= '{lvl: 1'b1, pol: 1'b0, any: 1'b0};
      end else if (sel) begin
        mask[g]    <= wr_data[MASK_LSB + FLD];
        cfg[g].lvl <= wr_data[LVL_LSB + FLD];
        cfg[g].pol <= wr_data[POL_LSB + FLD];
        cfg[g].any <= wr_data[ANY_LSB + FLD];
      end
    end

    assign clr[g] = sel & wr_data[CLR_LSB + FLD];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (rd_addr == 1'(i / SLOTS)) begin
        rd_data[MASK_LSB + i % SLOTS] = mask[i];
        rd_data[POL_LSB  + i % SLOTS] = cfg[i].pol;
        rd_data[ANY_LSB  + i % SLOTS] = cfg[i].any;
        rd_data[LVL_LSB  + i % SLOTS] = cfg[i].lvl;
        rd_data[RAW_LSB  + i % SLOTS] = raw[i];
      end
    end
  end
endmodule

// File: rtl/eirq_trigger_cfg.sv
module eirq_trigger_cfg
  import eirq_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [31:0]          wr_data,
  input  logic                 rd_addr,
  output logic [31:0]          rd_data,
  output logic [NUM_LINES-1:0] irq_o
);
  trig_cfg_t [NUM_LINES-1:0] cfg;
  logic [NUM_LINES-1:0]      mask, clr, pin_s, pin_prev;

  eirq_regs #(.NUM_LINES(NUM_LINES)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .raw(pin_s),
    .cfg(cfg), .mask(mask), .clr(clr), .rd_data(rd_data)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_ch
    eirq_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pin_i[g]),
      .q(pin_s[g]), .q_prev(pin_prev[g])
    );
    eirq_line line_i (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s[g]), .pin_prev(pin_prev[g]),
      .cfg(cfg[g]), .mask(mask[g]), .clr(clr[g]), .irq(irq_o[g])
    );

    // R8
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> mask[g]);
  end
endmodule

// File: tb/eirq_trigger_cfg_tb_top.sv
module eirq_trigger_cfg_tb_top;
  localparam int NL = 6;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] pin_i = '0;
  logic          wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NL-1:0] irq_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  eirq_trigger_cfg #(.NUM_LINES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  // {level-select, polarity, any-edge, pin before, pin after, expected irq}
  localparam logic [5:0] VEC [12] = '{
    6'b100_10_1, 6'b100_01_0,  // R4 level low
    6'b110_01_1, 6'b110_10_0,  // R4 level high
    6'b010_01_1, 6'b010_10_0,  // R5 rising
    6'b000_10_1, 6'b000_01_0,  // R6 falling
    6'b001_01_1, 6'b001_10_1,  // R7 both edges
    6'b111_01_1, 6'b111_10_0   // R12 level wins over any-edge
  };
  localparam int VREQ [12] = '{4, 4, 4, 4, 5, 5, 6, 6, 7, 7, 12, 12};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg0(logic lvl, logic pol, logic any, logic msk, logic ack);
    return 32'h000E0000 | 32'(ack) | (32'(msk) << 4) | (32'(pol) << 8)
         | (32'(any) << 12) | (32'(lvl) << 16);
  endfunction

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq after reset", 32'(irq_o), 32'h0);
    rd(1'b0, r); check("R1 reg0 reset", r, 32'h000F0000);
    rd(1'b1, r); check("R1 reg1 reset", r, 32'h00030000);

    // R2 layout, acknowledge reads 0; R3 absent slots read 0
    wr(1'b0, 32'hFFFFFFFF);
    rd(1'b0, r); check("R2 reg0 readback", r, 32'h000FFFF0);
    wr(1'b1, 32'hFFFFFFFF);
    rd(1'b1, r); check("R3 reg1 readback", r, 32'h00033330);
    check("R2 level-high with pins low", 32'(irq_o), 32'h0);
    wr(1'b1, 32'h00030000);

    // table walk on line 0
    for (int v = 0; v < 12; v++) begin
      wr(1'b0, cfg0(VEC[v][5], VEC[v][4], VEC[v][3], 1'b1, 1'b1));
      pin_i[0] = VEC[v][2];
      settle();
      wr(1'b0, cfg0(VEC[v][5], VEC[v][4], VEC[v][3], 1'b1, 1'b1));
      pin_i[0] = VEC[v][1];
      settle();
      check($sformatf("R%0d vector %0d", VREQ[v], v), 32'(irq_o[0]), 32'(VEC[v][0]));
    end

    // R5 exact latency and stickiness, R11 status latency
    pin_i[0] = 1'b0;
    wr(1'b0, cfg0(1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
    settle();
    wr(1'b0, cfg0(1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
    @(negedge clk); pin_i[0] = 1'b1;
    @(negedge clk);
    rd(1'b0, r); check("R11 status after one edge", 32'(r[20]), 32'h0);
    @(negedge clk);
    rd(1'b0, r); check("R11 status after two edges", 32'(r[20]), 32'h1);
    check("R5 no output after two edges", 32'(irq_o[0]), 32'h0);
    @(negedge clk);
    check("R5 output after three edges", 32'(irq_o[0]), 32'h1);
    pin_i[0] = 1'b0;
    settle();
    check("R5 sticky after pin falls", 32'(irq_o[0]), 32'h1);

    // R8 mask blocks, flag kept
    wr(1'b0, cfg0(1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    check("R8 masked output", 32'(irq_o[0]), 32'h0);
    wr(1'b0, cfg0(1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
    check("R8 unmask shows held flag", 32'(irq_o[0]), 32'h1);

    // R9 acknowledge
    wr(1'b0, cfg0(1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
    check("R9 write of 0 keeps flag", 32'(irq_o[0]), 32'h1);
    wr(1'b0, cfg0(1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
    check("R9 acknowledge clears flag", 32'(irq_o[0]), 32'h0);

    // R10 edge and acknowledge in the same cycle
    pin_i[0] = 1'b1; settle(); pin_i[0] = 1'b0; settle();
    check("R10 flag held before collision", 32'(irq_o[0]), 32'h1);
    @(negedge clk); pin_i[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 1'b0; wr_data = cfg0(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    @(negedge clk); wr_en = 1'b0;
    check("R10 edge wins over acknowledge", 32'(irq_o[0]), 32'h1);
    wr(1'b0, cfg0(1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
    check("R10 later acknowledge clears", 32'(irq_o[0]), 32'h0);

    // R3 line 4 lives in register 1 slot 0
    wr(1'b1, 32'h00020111);
    pin_i[4] = 1'b1;
    settle();
    check("R3 line 4 rising via reg1", 32'(irq_o[5:4]), 32'h1);
    rd(1'b1, r); check("R3 line 4 status in reg1", 32'(r[21:20]), 32'h1);
    check("R3 line 0 untouched", 32'(irq_o[0]), 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule